// File: doc/BRIEF.md
# SDRAM Host Command Front End

This block is the host-facing front end of an SDR SDRAM controller. A host drives a 3-bit opcode together with an address word. The block samples the opcode on the next rising edge. Memory operations are read, write, refresh, precharge of all banks and mode-register load. These are handed to a downstream command sequencer over a request/done handshake, and the host is acknowledged once the sequencer reports completion.

Two opcodes never reach the sequencer. They load the controller's own configuration from the address bus. One fills a timing/mode word holding CAS latency, RAS-to-CAS delay, refresh duration, a full-page flag and burst length. The other fills a 16-bit refresh period.

A free-running timer, reloaded from the refresh period, raises a refresh request toward the sequencer at fixed intervals. That request stays up until the sequencer confirms the refresh, so the host never needs to schedule refreshes. The configuration fields are driven out continuously for the sequencer and the data path to use.

Top module: `sdr_host_ctl`

## Requirements
- R1: Synchronous active-high reset clears the acknowledge, the sequencer request and the refresh request. It sets CAS latency 3, RAS-to-CAS 3, refresh duration 7, page flag 0, burst length 8 and refresh period REF_DEFAULT. The first refresh request rises on the REF_DEFAULT-th clock edge after reset is released.
- R2: Opcodes 3'b001 (read), 3'b010 (write), 3'b011 (refresh), 3'b100 (precharge all) and 3'b101 (mode load) are memory operations. An accepted memory opcode raises seq_req after the sampling edge, with seq_op equal to the opcode and seq_addr equal to the sampled address. All three hold steady and host_ack stays low until seq_done is sampled high.
- R3: On the edge that samples seq_done with seq_req high, seq_req falls and host_ack is high for exactly one clock cycle. For a configuration load (3'b110 or 3'b111), host_ack is high in the cycle right after the sampling edge. host_ack is never high for two cycles in a row.
- R4: The opcode is only accepted while no request is outstanding and host_ack is low. Opcode 3'b000 does nothing. Any opcode presented while the sequencer is busy, or during the acknowledge cycle, leaves the configuration and the timer untouched.
- R5: Opcode 3'b110 loads address bits [1:0] into CAS latency, [3:2] into RAS-to-CAS delay, [7:4] into refresh duration, [8] into the page flag (1 = full page) and [12:9] into burst length. It raises no sequencer request.
- R6: When address bits [12:9] of a 3'b110 load are not 1, 2, 4 or 8, the burst length keeps its previous value while the other fields still load.
- R7: Opcode 3'b111 loads address bits [15:0] into the refresh period and restarts the timer. With a loaded period P of at least 2, the next refresh request rises on the P-th clock edge after the loading edge.
- R8: With the timer running, a refresh request is raised every P clock edges. A period of 0 behaves as a period of 1: the request is re-raised on every edge, even while ref_done is high.
- R9: ref_req stays high until ref_done is sampled high. A timer expiry while a request is already pending adds no second request.
- R10: For read and write, seq_autopre is the inverse of the page flag at acceptance. For all other memory operations it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_op | input | 3 | Host opcode |
| host_addr | input | ADDR_W | Host address / configuration value |
| host_ack | output | 1 | One-cycle acknowledge of a host command |
| seq_req | output | 1 | Request to the command sequencer |
| seq_op | output | 3 | Memory opcode forwarded to the sequencer |
| seq_addr | output | ADDR_W | Address forwarded to the sequencer |
| seq_autopre | output | 1 | Access closes its row automatically |
| seq_done | input | 1 | Sequencer finished the forwarded operation |
| ref_req | output | 1 | Automatic refresh request |
| ref_done | input | 1 | Sequencer finished the automatic refresh |
| cfg_cas | output | 2 | CAS latency |
| cfg_rcd | output | 2 | RAS-to-CAS delay |
| cfg_ref_dur | output | 4 | Refresh duration in clocks |
| cfg_page | output | 1 | Full-page mode flag |
| cfg_burst | output | 4 | Burst length (1, 2, 4 or 8) |
| cfg_ref_period | output | 16 | Clocks between automatic refreshes |

## Verification
The bench builds the block with ADDR_W = 20 and REF_DEFAULT = 60. This makes the first reset-default refresh expiry reachable in a few dozen cycles, while the address remains wide enough to carry every configuration field. Loaded periods of 0, 1, 9 and 20 bring reload, pending-hold, no-double-count and every-clock expiry within a short window. Random opcodes with random sequencer latencies of 0 to 4 cycles, plus ignored opcodes driven during busy and acknowledge cycles, exercise the handshake against the bench's own configuration model.

// File: rtl/sdr_host_pkg.sv
package sdr_host_pkg;

    localparam int PERIOD_W   = 16;
    localparam int TCFG_W     = 13;
    localparam int CAS_LSB    = 0;
    localparam int RCD_LSB    = 2;
    localparam int DUR_LSB    = 4;
    localparam int PAGE_BIT   = 8;
    localparam int BURST_LSB  = 9;

    typedef enum logic [2:0] {
        OP_IDLE = 3'b000,
        OP_RD   = 3'b001,
        OP_WR   = 3'b010,
        OP_AREF = 3'b011,
        OP_PALL = 3'b100,
        OP_MRS  = 3'b101,
        OP_TCFG = 3'b110,
        OP_RPER = 3'b111
    } host_op_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic [3:0] burst;
        logic       page;
        logic [3:0] ref_dur;
        logic [1:0] rcd;
        logic [1:0] cas;
    } timing_cfg_t;

    typedef struct packed {
        logic     mem;
        logic     ld_timing;
        logic     ld_period;
        host_op_e op;
    } dec_t;

    localparam timing_cfg_t TIMING_RESET = '{
        burst:   4'd8,
        page:    1'b0,
        ref_dur: 4'd7,
        rcd:     2'd3,
        cas:     2'd3
    };

    function automatic logic burst_legal(input logic [3:0] b);
        return (b == 4'd1) || (b == 4'd2) || (b == 4'd4) || (b == 4'd8);
    endfunction

    function automatic timing_cfg_t unpack_timing(input logic [TCFG_W-1:0] w,
                                                  input timing_cfg_t old);
        timing_cfg_t t;
        t.cas     = w[CAS_LSB +: 2];
        t.rcd     = w[RCD_LSB +: 2];
        t.ref_dur = w[DUR_LSB +: 4];
        t.page    = w[PAGE_BIT];
        t.burst   = burst_legal(w[BURST_LSB +: 4]) ? w[BURST_LSB +: 4] : old.burst;
        return t;
    endfunction

    function automatic logic closes_row(input host_op_e op, input logic page);
        return ((op == OP_RD) || (op == OP_WR)) && !page;
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_host_pkg::*;
(
    input  logic [2:0] op_raw,
    input  logic       accept,
    output dec_t       dec
);

    always_comb begin
        dec.op        = host_op_e'(op_raw);
        dec.mem       = 1'b0;
        dec.ld_timing = 1'b0;
        dec.ld_period = 1'b0;
        if (accept) begin
            case (dec.op)
                OP_IDLE: ;
                OP_TCFG: dec.ld_timing = 1'b1;
                OP_RPER: dec.ld_period = 1'b1;
                default: dec.mem       = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/sdr_cfg_regs.sv
module sdr_cfg_regs
    import sdr_host_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int REF_DEFAULT = 1562
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_timing,
    input  logic                ld_period,
    input  logic [ADDR_W-1:0]   wdata,
    output timing_cfg_t         tcfg,
    output logic [PERIOD_W-1:0] period
);

    localparam logic [PERIOD_W-1:0] PERIOD_RST = PERIOD_W'(REF_DEFAULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcfg   <= TIMING_RESET;
            period <= PERIOD_RST;
        end else begin
            if (ld_timing)
                tcfg <= unpack_timing(wdata[TCFG_W-1:0], tcfg);
            if (ld_period)
                period <= wdata[PERIOD_W-1:0];
        end
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer
    import sdr_host_pkg::*;
#(
    parameter int REF_DEFAULT = 1562
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reload,
    input  logic [PERIOD_W-1:0] new_period,
    input  logic [PERIOD_W-1:0] period,
    input  logic                done,
    output logic                req
);

    localparam logic [PERIOD_W-1:0] CNT_RST = PERIOD_W'(REF_DEFAULT);

    logic [PERIOD_W-1:0] cnt;
    logic                expire;

    assign expire = !reload && (cnt <= PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_RST;
            req <= 1'b0;
        end else begin
            if (reload)
                cnt <= new_period;
            else if (expire)
                cnt <= period;
            else
                cnt <= cnt - PERIOD_W'(1);

            if (expire)
                req <= 1'b1;
            else if (done)
                req <= 1'b0;
        end
    end

endmodule

// File: rtl/sdr_host_ctl.sv
module sdr_host_ctl
    import sdr_host_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int REF_DEFAULT = 1562
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_op,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_ack,
    output logic              seq_req,
    output logic [2:0]        seq_op,
    output logic [ADDR_W-1:0] seq_addr,
    output logic              seq_autopre,
    input  logic              seq_done,
    output logic              ref_req,
    input  logic              ref_done,
    output logic [1:0]        cfg_cas,
    output logic [1:0]        cfg_rcd,
    output logic [3:0]        cfg_ref_dur,
    output logic              cfg_page,
    output logic [3:0]        cfg_burst,
    output logic [15:0]       cfg_ref_period
);

    hs_state_e           state_q;
    dec_t                dec;
    timing_cfg_t         tcfg;
    logic [PERIOD_W-1:0] period;
    logic                idle;

    assign idle = (state_q == HS_IDLE);

    sdr_cmd_decode u_dec (
        .op_raw (host_op),
        .accept (idle),
        .dec    (dec)
    );

    sdr_cfg_regs #(
        .ADDR_W      (ADDR_W),
        .REF_DEFAULT (REF_DEFAULT)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .ld_timing (dec.ld_timing),
        .ld_period (dec.ld_period),
        .wdata     (host_addr),
        .tcfg      (tcfg),
        .period    (period)
    );

    sdr_refresh_timer #(
        .REF_DEFAULT (REF_DEFAULT)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .reload     (dec.ld_period),
        .new_period (host_addr[PERIOD_W-1:0]),
        .period     (period),
        .done       (ref_done),
        .req        (ref_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= HS_IDLE;
            seq_op      <= 3'b000;
            seq_addr    <= '0;
            seq_autopre <= 1'b0;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (dec.mem) begin
                        state_q     <= HS_WAIT;
                        seq_op      <= dec.op;
                        seq_addr    <= host_addr;
                        seq_autopre <= closes_row(dec.op, tcfg.page);
                    end else if (dec.ld_timing || dec.ld_period) begin
                        state_q <= HS_ACK;
                    end
                end
                HS_WAIT: if (seq_done) state_q <= HS_ACK;
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    assign host_ack       = (state_q == HS_ACK);
    assign seq_req        = (state_q == HS_WAIT);
    assign cfg_cas        = tcfg.cas;
    assign cfg_rcd        = tcfg.rcd;
    assign cfg_ref_dur    = tcfg.ref_dur;
    assign cfg_page       = tcfg.page;
    assign cfg_burst      = tcfg.burst;
    assign cfg_ref_period = period;

endmodule

// File: rtl/sdr_host_ctl_chk.sv
module sdr_host_ctl_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        host_op,
    input logic              host_ack,
    input logic              seq_req,
    input logic [2:0]        seq_op,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              seq_done,
    input logic              ref_req,
    input logic              ref_done,
    input logic [3:0]        cfg_burst
);

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R3
    ack_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_done) |=> (host_ack && !seq_req));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_req && !seq_done) |=> (seq_req && !host_ack && $stable(seq_op) && $stable(seq_addr)));

    // R2
    req_op_chk: assert property (@(posedge clk) disable iff (rst)
        seq_req |-> (seq_op != 3'b000 && seq_op != 3'b110 && seq_op != 3'b111));

    // R4
    req_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_req) |-> ($past(host_op) == seq_op && !$past(host_ack)));

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_done) |=> ref_req);

    // R6
    burst_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cfg_burst) == 1);

endmodule

bind sdr_host_ctl sdr_host_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_op   (host_op),
    .host_ack  (host_ack),
    .seq_req   (seq_req),
    .seq_op    (seq_op),
    .seq_addr  (seq_addr),
    .seq_done  (seq_done),
    .ref_req   (ref_req),
    .ref_done  (ref_done),
    .cfg_burst (cfg_burst)
);

// File: tb/sdr_host_ctl_tb.sv
module sdr_host_ctl_tb;

    localparam int AW   = 20;
    localparam int RDEF = 60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    host_op = 3'b000;
    logic [AW-1:0] host_addr = '0;
    logic          seq_done = 1'b0;
    logic          ref_done = 1'b0;
    logic          host_ack, seq_req, seq_autopre, ref_req, cfg_page;
    logic [2:0]    seq_op;
    logic [AW-1:0] seq_addr;
    logic [1:0]    cfg_cas, cfg_rcd;
    logic [3:0]    cfg_ref_dur, cfg_burst;
    logic [15:0]   cfg_ref_period;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [1:0]  e_cas = 2'd3, e_rcd = 2'd3;
    logic [3:0]  e_dur = 4'd7, e_bl = 4'd8;
    logic        e_page = 1'b0;
    logic [15:0] e_per = 16'(RDEF);

    always #4 clk = ~clk;

    sdr_host_ctl #(.ADDR_W(AW), .REF_DEFAULT(RDEF)) u_dut (
        .clk(clk), .rst(rst), .host_op(host_op), .host_addr(host_addr),
        .host_ack(host_ack), .seq_req(seq_req), .seq_op(seq_op),
        .seq_addr(seq_addr), .seq_autopre(seq_autopre), .seq_done(seq_done),
        .ref_req(ref_req), .ref_done(ref_done), .cfg_cas(cfg_cas),
        .cfg_rcd(cfg_rcd), .cfg_ref_dur(cfg_ref_dur), .cfg_page(cfg_page),
        .cfg_burst(cfg_burst), .cfg_ref_period(cfg_ref_period)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cfg();
        return {3'b0, e_cas, e_rcd, e_dur, e_page, e_bl, e_per};
    endfunction

    function automatic logic [31:0] act_cfg();
        return {3'b0, cfg_cas, cfg_rcd, cfg_ref_dur, cfg_page, cfg_burst, cfg_ref_period};
    endfunction

    function automatic bit legal_bl(input logic [3:0] b);
        return b == 1 || b == 2 || b == 4 || b == 8;
    endfunction

    function automatic bit is_mem(input logic [2:0] op);
        return op >= 3'b001 && op <= 3'b101;
    endfunction

    task automatic model_load(input logic [2:0] op, input logic [AW-1:0] a);
        if (op == 3'b110) begin
            e_cas = a[1:0]; e_rcd = a[3:2]; e_dur = a[7:4]; e_page = a[8];
            if (legal_bl(a[12:9])) e_bl = a[12:9];
        end else if (op == 3'b111) begin
            e_per = a[15:0];
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a, input int lat);
        bit ok;
        bit ap;
        ap = (op == 3'b001 || op == 3'b010) && !e_page;
        host_op = op; host_addr = a;
        @(negedge clk);
        if (is_mem(op)) begin
            // R2 forwarding and R10 autoprecharge
            chk(seq_req == 1'b1 && host_ack == 1'b0, "R2 req", {seq_req, host_ack}, 2'b10);
            chk(seq_op == op, "R2 op", seq_op, op);
            chk(seq_addr == a, "R2 addr", seq_addr, a);
            chk(seq_autopre == ap, "R10 autopre", seq_autopre, ap);
            // R4: config opcode while busy must be ignored
            host_op = 3'($urandom_range(6, 7)); host_addr = AW'($urandom);
            ok = 1;
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                if (!seq_req || host_ack || seq_op != op || seq_addr != a) ok = 0;
            end
            chk(ok, "R2 hold until done", ok, 1);
            seq_done = 1'b1;
            @(negedge clk);
            seq_done = 1'b0;
            chk(host_ack == 1'b1 && seq_req == 1'b0, "R3 ack after done", {host_ack, seq_req}, 2'b10);
        end else begin
            model_load(op, a);
            chk(host_ack == 1'b1 && seq_req == 1'b0, "R3 cfg ack", {host_ack, seq_req}, 2'b10);
            chk(act_cfg() == exp_cfg(), "R5 cfg load", act_cfg(), exp_cfg());
            // R4: opcode during acknowledge cycle must be ignored
            host_op = 3'b110; host_addr = AW'($urandom);
        end
        @(negedge clk);
        host_op = 3'b000;
        chk(host_ack == 1'b0, "R3 single ack", host_ack, 0);
        chk(act_cfg() == exp_cfg(), "R4 ignored opcode", act_cfg(), exp_cfg());
        @(negedge clk);
        chk(host_ack == 1'b0 && seq_req == 1'b0, "R4 nop idle", {host_ack, seq_req}, 0);
    endtask

    task automatic ref_test(input int p);
        ref_done = 1'b1;
        do_cmd(3'b111, AW'(p), 0);
        ref_done = 1'b0;
        chk(ref_req == 1'b0, "R7 cleared after load", ref_req, 0);
        for (int k = 3; k <= 3 * p; k++) begin
            @(negedge clk);
            if (k == p - 1) chk(ref_req == 1'b0, "R7 before first expiry", ref_req, 0);
            if (k == p)     chk(ref_req == 1'b1, "R7 first expiry", ref_req, 1);
            if (k == 2 * p + 3) begin
                chk(ref_req == 1'b1, "R9 held while pending", ref_req, 1);
                ref_done = 1'b1;
            end
            if (k == 2 * p + 4) begin
                chk(ref_req == 1'b0, "R9 no double request", ref_req, 0);
                ref_done = 1'b0;
            end
            if (k == 3 * p - 1) chk(ref_req == 1'b0, "R8 before next expiry", ref_req, 0);
            if (k == 3 * p)     chk(ref_req == 1'b1, "R8 periodic expiry", ref_req, 1);
        end
    endtask

    task automatic tiny_period(input int p);
        ref_done = 1'b1;
        do_cmd(3'b111, AW'(p), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ref_req == 1'b1, "R8 every clock", ref_req, 1);
        end
        ref_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(host_ack == 0 && seq_req == 0 && ref_req == 0, "R1 outputs",
            {host_ack, seq_req, ref_req}, 0);
        chk(act_cfg() == exp_cfg(), "R1 config", act_cfg(), exp_cfg());
        for (int k = 1; k <= RDEF; k++) begin
            if (k > 1) @(negedge clk);
            else @(negedge clk);
            if (k == RDEF - 1) chk(ref_req == 1'b0, "R1 default early", ref_req, 0);
            if (k == RDEF)     chk(ref_req == 1'b1, "R1 default expiry", ref_req, 1);
        end
        ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;

        // directed: R5/R6 burst legality
        do_cmd(3'b110, AW'({4'd3, 1'b0, 4'd5, 2'd2, 2'd2}), 0);
        chk(cfg_burst == 4'd8, "R6 illegal burst kept", cfg_burst, 8);
        do_cmd(3'b110, AW'({4'd1, 1'b1, 4'd9, 2'd1, 2'd3}), 0);
        chk(cfg_burst == 4'd1 && cfg_page == 1'b1, "R5 burst 1 page", {cfg_burst, cfg_page}, 5'b00011);
        do_cmd(3'b110, AW'({4'd0, 1'b1, 4'd2, 2'd3, 2'd2}), 1);
        chk(cfg_burst == 4'd1, "R6 zero burst kept", cfg_burst, 1);
        // R10 page mode on: read/write keep row open
        do_cmd(3'b001, AW'(20'h1_2345), 2);
        do_cmd(3'b010, AW'(20'h0_0F0F), 0);
        do_cmd(3'b110, AW'({4'd4, 1'b0, 4'd6, 2'd2, 2'd2}), 0);
        do_cmd(3'b010, AW'(20'hF_FFFF), 3);
        do_cmd(3'b101, AW'(20'h0_0032), 1);
        do_cmd(3'b100, AW'(20'h0_0400), 4);
        do_cmd(3'b011, AW'(20'h0_0000), 0);

        // refresh timer directed cases
        ref_test(9);
        ref_test(20);
        tiny_period(0);
        tiny_period(1);
        ref_done = 1'b1;
        do_cmd(3'b111, AW'(16'd5000), 0);
        ref_done = 1'b0;
        chk(ref_req == 1'b0 && cfg_ref_period == 16'd5000, "R7 long period", {ref_req, cfg_ref_period}, 5000);

        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(1, 7));
            if (op == 3'b111) do_cmd(op, AW'($urandom_range(3000, 65535)), 0);
            else do_cmd(op, AW'($urandom), $urandom_range(0, 4));
        end
        report();
    end

endmodule